// File: doc/BRIEF.md
# Paged Indirect Register Bridge

This block sits on the slave side of a 16-bit register bus and opens a 512-entry address window onto a 22-bit target register space. One slot in the window holds a page register. Software loads the upper 13 address bits into that slot, and every other slot in the window then reaches the target register whose address is the stored page joined with the 9-bit window offset.

Writes to the target are posted: the request, the full address and the data leave the bridge in the same cycle the host presents them, and the host completes at once. A read to the target sends a one-cycle request. It then holds the host in a wait state until the target returns data with a valid strobe, and passes that data back in the cycle it arrives. Accesses to the page slot stay inside the bridge.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset the stored page is zero, `t_req` is low and `h_ready` is high while the host is idle.
- R2: A host write to window offset 0x1FE stores `h_wdata[12:0]` as the page, and bits 15:13 of the written data are discarded. A host read of offset 0x1FE completes in one cycle and returns the page in bits 12:0, with bits 15:13 read as zero.
- R3: A host access to offset 0x1FE, whether read or write, never raises `t_req`.
- R4: A host write to any other offset raises `t_req` and `t_wr` in the same cycle. In that cycle `t_addr` is {page, offset}, with the page in bits 21:9 and the offset in bits 8:0, `t_wdata` equals `h_wdata`, and `h_ready` is high.
- R5: A host read to any other offset raises `t_req` with `t_wr` low and `t_addr` equal to {page, offset}. `h_ready` stays low until the first cycle in which `t_rvalid` is high. In that cycle `h_ready` is high and `h_rdata` equals `t_rdata`.
- R6: `t_req` stays high for exactly one cycle per forwarded read and is not raised again while that read waits.
- R7: When no read is pending and no page read is in progress, `h_rdata` reads zero, and a `t_rvalid` pulse neither changes `h_rdata` nor alters the stored page.
- R8: Window offsets 0x000 and 0x1FF, and the largest page 0x1FFF, are forwarded with the full address formed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_sel | input | 1 | Host access request, held until `h_ready` |
| h_wr | input | 1 | Host access is a write |
| h_offs | input | 9 | Offset inside the window |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data |
| h_ready | output | 1 | Host access completes this cycle |
| t_req | output | 1 | Target access strobe |
| t_wr | output | 1 | Target access is a write |
| t_addr | output | 22 | Full target address |
| t_wdata | output | 16 | Target write data |
| t_rdata | input | 16 | Target read data |
| t_rvalid | input | 1 | Target read data is valid |

## Verification
A corrupted page register shows up in the next forwarded access, because the upper bits of `t_addr` change in that same cycle. It also shows up as soon as the page slot is read back. A wait flag that is stuck or cleared too early appears on the host side within one cycle. It either stalls a write or a page access, completes a read before `t_rvalid`, or lets a second `t_req` go out during the wait. The bench therefore checks the address in every request cycle and checks `h_ready` in every cycle of each read wait.

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge #(
  parameter int OFFS_W = 9,
  parameter int PAGE_W = 13,
  parameter int DATA_W = 16,
  parameter logic [OFFS_W-1:0] PAGE_SLOT = 9'h1FE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     h_sel,
  input  logic                     h_wr,
  input  logic [OFFS_W-1:0]        h_offs,
  input  logic [DATA_W-1:0]        h_wdata,
  output logic [DATA_W-1:0]        h_rdata,
  output logic                     h_ready,
  output logic                     t_req,
  output logic                     t_wr,
  output logic [OFFS_W+PAGE_W-1:0] t_addr,
  output logic [DATA_W-1:0]        t_wdata,
  input  logic [DATA_W-1:0]        t_rdata,
  input  logic                     t_rvalid
);
  localparam int PAD_W = DATA_W - PAGE_W;

  logic [PAGE_W-1:0] page_q;
  logic              wait_q;
  logic              hit_page, fwd, fwd_rd;
  logic              unused_hi;

  assign hit_page = h_sel && !wait_q && (h_offs == PAGE_SLOT);
  assign fwd      = h_sel && !wait_q && (h_offs != PAGE_SLOT);
  assign fwd_rd   = fwd && !h_wr;

  assign t_req   = fwd;
  assign t_wr    = h_wr;
  assign t_addr  = {page_q, h_offs};
  assign t_wdata = h_wdata;

  assign h_ready = wait_q ? t_rvalid : !fwd_rd;
  assign h_rdata = wait_q ? (t_rvalid ? t_rdata : '0)
                 : (hit_page && !h_wr) ? {{PAD_W{1'b0}}, page_q} : '0;

  assign unused_hi = ^h_wdata[DATA_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      wait_q <= 1'b0;
    end else begin
      if (hit_page && h_wr)
        page_q <= h_wdata[PAGE_W-1:0];
      if (fwd_rd)
        wait_q <= 1'b1;
      else if (wait_q && t_rvalid)
        wait_q <= 1'b0;
    end
  end

  AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_sel && h_wr && h_offs == PAGE_SLOT) |=> $stable(page_q)); // R2
  AST_PAGE_RB_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && !h_wr && h_offs == PAGE_SLOT && h_ready) |-> h_rdata[DATA_W-1:PAGE_W] == '0); // R2
  AST_NO_PAGE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    t_req |-> t_addr[OFFS_W-1:0] != PAGE_SLOT); // R3
  AST_ADDR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    t_req |-> t_addr[OFFS_W+PAGE_W-1:OFFS_W] == page_q); // R4
  AST_WR_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    (t_req && t_wr) |-> h_ready); // R4
  AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !t_rvalid) |-> !h_ready); // R5
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (t_req && !t_wr) |=> !t_req); // R6
endmodule

// File: tb/tb_paged_reg_bridge.sv
module tb_paged_reg_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_sel = 1'b0, h_wr = 1'b0;
  logic [8:0] h_offs = '0;
  logic [15:0] h_wdata = '0, h_rdata;
  logic h_ready, t_req, t_wr;
  logic [21:0] t_addr;
  logic [15:0] t_wdata;
  logic [15:0] t_rdata = '0;
  logic t_rvalid = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  paged_reg_bridge dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic page_wr(input logic [15:0] d);
    @(negedge clk);
    h_sel = 1; h_wr = 1; h_offs = 9'h1FE; h_wdata = d;
    #2;
    chk("R3 page write no t_req", t_req, 0);
    chk("R2 page write ready", h_ready, 1);
    @(posedge clk); @(negedge clk);
    h_sel = 0; h_wr = 0;
  endtask

  task automatic page_rd(input logic [15:0] exp);
    @(negedge clk);
    h_sel = 1; h_wr = 0; h_offs = 9'h1FE;
    #2;
    chk("R3 page read no t_req", t_req, 0);
    chk("R2 page read ready", h_ready, 1);
    chk("R2 page readback", h_rdata, exp);
    @(posedge clk); @(negedge clk);
    h_sel = 0;
  endtask

  task automatic tgt_wr(input logic [8:0] o, input logic [15:0] d, input logic [21:0] ea);
    @(negedge clk);
    h_sel = 1; h_wr = 1; h_offs = o; h_wdata = d;
    #2;
    chk("R4 write t_req", t_req, 1);
    chk("R4 write t_wr", t_wr, 1);
    chk("R4/R8 write addr", t_addr, ea);
    chk("R4 write data", t_wdata, d);
    chk("R4 write posted", h_ready, 1);
    @(posedge clk); @(negedge clk);
    h_sel = 0; h_wr = 0;
  endtask

  task automatic tgt_rd(input logic [8:0] o, input logic [21:0] ea, input int lat, input logic [15:0] d);
    @(negedge clk);
    h_sel = 1; h_wr = 0; h_offs = o;
    #2;
    chk("R5 read t_req", t_req, 1);
    chk("R5 read t_wr", t_wr, 0);
    chk("R5/R8 read addr", t_addr, ea);
    chk("R5 read stall", h_ready, 0);
    @(posedge clk);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk); #2;
      chk("R6 no reissue", t_req, 0);
      chk("R5 still stalled", h_ready, 0);
      @(posedge clk);
    end
    @(negedge clk);
    t_rvalid = 1; t_rdata = d;
    #2;
    chk("R6 no req on return", t_req, 0);
    chk("R5 ready on rvalid", h_ready, 1);
    chk("R5 read data", h_rdata, d);
    @(posedge clk); @(negedge clk);
    h_sel = 0; t_rvalid = 0; t_rdata = '0;
    #2;
    chk("R5 back to idle", h_ready, 1);
  endtask

  task automatic stray_valid();
    @(negedge clk);
    t_rvalid = 1; t_rdata = 16'hDEAD;
    #2;
    chk("R7 idle rdata zero", h_rdata, 0);
    chk("R7 idle ready", h_ready, 1);
    chk("R7 no t_req", t_req, 0);
    @(posedge clk); @(negedge clk);
    t_rvalid = 0; t_rdata = '0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk("R1 reset t_req", t_req, 0);
    chk("R1 reset ready", h_ready, 1);
    chk("R1 reset rdata", h_rdata, 0);
    rst_n = 1;
    page_rd(16'h0000);                       // R1 page resets to zero
    tgt_wr(9'h005, 16'h1234, 22'h000005);    // R4 with page 0
    page_wr(16'hE0A5);                       // R2 upper bits dropped
    page_rd(16'h00A5);
    tgt_wr(9'h033, 16'hBEEF, {13'h00A5, 9'h033});
    tgt_rd(9'h044, {13'h00A5, 9'h044}, 0, 16'h5A5A);
    tgt_rd(9'h100, {13'h00A5, 9'h100}, 3, 16'hC3C3);
    page_wr(16'hFFFF);                       // R8 max page
    page_rd(16'h1FFF);
    tgt_wr(9'h1FF, 16'h0F0F, 22'h3FFFFF);    // R8 top offset
    tgt_rd(9'h000, {13'h1FFF, 9'h000}, 1, 16'hA5A5); // R8 offset zero
    stray_valid();                           // R7
    page_rd(16'h1FFF);                       // R7 page unchanged
    page_wr(16'h0001);
    tgt_rd(9'h1FD, {13'h0001, 9'h1FD}, 2, 16'h7777);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule